// File: doc/BRIEF.md
# Multi-Cycle Restoring Divider

This block divides one 5-bit unsigned integer by another and returns a 5-bit quotient and a 5-bit remainder. It takes several clock cycles to do so and uses one subtractor for the whole operation. On each cycle it shifts the next dividend bit into a partial remainder and tries subtracting the divisor from it. When that trial subtraction does not borrow, the difference is kept and a quotient bit of 1 is recorded. When it borrows, the partial remainder is left unchanged and a quotient bit of 0 is recorded.

The handshake has a single start input and a single ready output. When ready is high, a start pulse loads both operands on that clock edge. The operand inputs are only sampled at that edge, so they may change afterwards. Ready then stays low while the five iterations run. It rises again once the result is valid. The quotient and remainder outputs keep that result until the next accepted start. A zero divisor gives a defined result, with the same timing as any other division.

Top module: `restore_div`

## Requirements
- R1: After reset, ready is 1 and both quotient and remainder read 0.
- R2: A start seen high while ready is 1 captures dividend and divisor on that same clock edge. Later changes on the operand inputs do not affect the result.
- R3: Ready reads 0 after the accepting edge and after the next four edges. It reads 1 again after the fifth edge following the accepting edge, which is six edges in all.
- R4: When ready returns for a nonzero divisor B and dividend A, the quotient equals floor(A/B) and the remainder equals A mod B.
- R5: A zero divisor yields a quotient of all ones (31) and a remainder equal to the dividend, with the R3 timing.
- R6: Start is ignored while ready is 0. A start held high or pulsed with new operands during a division changes neither the result nor the R3 timing.
- R7: While ready is 1 and start is 0, quotient and remainder keep their values from the most recent division.
- R8: Each iteration uses the single trial subtraction, and with a nonzero divisor the partial remainder stays below the divisor. The final remainder is therefore always less than a nonzero divisor.
- R9: A start given in the cycle where ready has just returned is accepted at once, so back-to-back divisions lose no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Requests a division; sampled only while ready is 1 |
| dividendIn | input | 5 | Dividend, valid only in the accepting cycle |
| divisorIn | input | 5 | Divisor, valid only in the accepting cycle |
| readyOut | output | 1 | 1 when idle and the result is valid |
| quotOut | output | 5 | Quotient of the most recent division |
| remOut | output | 5 | Remainder of the most recent division |

## Verification
The accepting edge is counted as edge zero. Ready must read 0 after edges zero through four, and both the ready flag and the two results must be correct after edge five. The bench drives inputs on falling edges and samples outputs on the falling edge after each of those six edges, so each value is checked exactly when it becomes due. Hold behaviour and ignored starts are checked on the same counted schedule: the bench scrambles the operand inputs, or asserts start, between those samples, and then rechecks the outputs.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } strobe_t;
endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  output strobe_t strb,
  output logic    readyOut
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  typedef enum logic {S_IDLE, S_RUN} state_t;
  state_t stateQ;
  logic [CNT_W-1:0] iterCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      iterCnt <= '0;
    end else begin
      case (stateQ)
        S_IDLE: if (startReq) begin
          stateQ  <= S_RUN;
          iterCnt <= '0;
        end
        default: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST) stateQ <= S_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    strb.load = (stateQ == S_IDLE) && startReq;
    strb.step = (stateQ == S_RUN);
    readyOut  = (stateQ == S_IDLE);
  end

  a_r3_drop: assert property (@(posedge clk) disable iff (!rstN)
    (readyOut && startReq) |=> !readyOut);
  a_r3_finish: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && iterCnt == LAST) |=> readyOut);
  a_r6_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && iterCnt != LAST) |=> (!readyOut && iterCnt == $past(iterCnt) + 1'b1));
endmodule

// File: rtl/rdiv_path.sv
module rdiv_path
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] dividendIn,
  input  logic [WIDTH-1:0] divisorIn,
  output logic [WIDTH-1:0] quotOut,
  output logic [WIDTH-1:0] remOut
);
  // dqReg: dividend bits leave at the top while quotient bits enter at the bottom
  logic [WIDTH-1:0] dqReg;
  logic [WIDTH-1:0] dvsReg;
  logic [WIDTH:0]   parRem;
  logic [WIDTH:0]   shifted;
  logic [WIDTH+1:0] trial;
  logic             borrow;

  always_comb begin
    shifted = {parRem[WIDTH-1:0], dqReg[WIDTH-1]};
    trial   = {1'b0, shifted} - {2'b00, dvsReg};  // the one shared subtractor
    borrow  = trial[WIDTH+1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqReg  <= '0;
      dvsReg <= '0;
      parRem <= '0;
    end else if (strb.load) begin
      dqReg  <= dividendIn;
      dvsReg <= divisorIn;
      parRem <= '0;
    end else if (strb.step) begin
      dqReg  <= {dqReg[WIDTH-2:0], ~borrow};
      parRem <= borrow ? shifted : trial[WIDTH:0];
    end
  end

  assign quotOut = dqReg;
  assign remOut  = parRem[WIDTH-1:0];

  a_r2_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (dqReg == $past(dividendIn) && dvsReg == $past(divisorIn) && parRem == '0));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> ($stable(dqReg) && $stable(parRem)));
  a_r8_rem_bound: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && dvsReg != '0) |=> (parRem < {1'b0, dvsReg}));
  a_r5_zero_ones: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && dvsReg == '0) |=> dqReg[0]);
endmodule

// File: rtl/restore_div.sv
module restore_div
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [WIDTH-1:0] dividendIn,
  input  logic [WIDTH-1:0] divisorIn,
  output logic             readyOut,
  output logic [WIDTH-1:0] quotOut,
  output logic [WIDTH-1:0] remOut
);
  strobe_t strb;

  rdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .strb(strb), .readyOut(readyOut)
  );

  rdiv_path #(.WIDTH(WIDTH)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb),
    .dividendIn(dividendIn), .divisorIn(divisorIn),
    .quotOut(quotOut), .remOut(remOut)
  );
endmodule

// File: tb/restore_div_tb.sv
module restore_div_tb;
  localparam int W = 5;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [W-1:0] dividendIn = '0, divisorIn = '0;
  logic readyOut;
  logic [W-1:0] quotOut, remOut;
  int checks = 0, errors = 0, cycles = 0;

  restore_div #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dividendIn(dividendIn),
    .divisorIn(divisorIn), .readyOut(readyOut), .quotOut(quotOut), .remOut(remOut)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int expQ(int a, int b);
    return (b == 0) ? (1 << W) - 1 : a / b;
  endfunction
  function automatic int expR(int a, int b);
    return (b == 0) ? a : a % b;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge with ready high. Issues one division and returns
  // at the falling edge after the fifth edge past acceptance. busyMode: 0 quiet,
  // 1 start held high, 2 start pulsed with other operands while busy.
  task automatic runDiv(int a, int b, int busyMode);
    startReq = 1'b1;
    dividendIn = W'(a);
    divisorIn = W'(b);
    @(posedge clk);
    @(negedge clk);
    chk("R3 ready low after accept", int'(readyOut), 0);
    dividendIn = W'($urandom);
    divisorIn = W'($urandom);
    startReq = (busyMode != 0);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R3 ready low while busy", int'(readyOut), 0);
      dividendIn = W'($urandom);
      divisorIn = W'($urandom);
      if (busyMode == 2) startReq = ~startReq;
    end
    startReq = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R3 ready back after six edges", int'(readyOut), 1);
    chk(b == 0 ? "R5 quotient" : "R4 quotient", int'(quotOut), expQ(a, b));
    chk(b == 0 ? "R5 remainder" : "R4 remainder", int'(remOut), expR(a, b));
    if (b != 0) chk("R8 remainder below divisor", int'(remOut < W'(b)), 1);
  endtask

  task automatic idleHold(int n);
    logic [W-1:0] q0, r0;
    q0 = quotOut;
    r0 = remOut;
    for (int i = 0; i < n; i++) begin
      dividendIn = W'($urandom);
      divisorIn = W'($urandom);
      @(posedge clk);
      @(negedge clk);
    end
    chk("R7 quotient held", int'(quotOut), int'(q0));
    chk("R7 remainder held", int'(remOut), int'(r0));
    chk("R7 ready stays high", int'(readyOut), 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk("R1 ready after reset", int'(readyOut), 1);
    chk("R1 quotient after reset", int'(quotOut), 0);
    chk("R1 remainder after reset", int'(remOut), 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", int'(readyOut), 1);
    chk("R1 quotient after release", int'(quotOut), 0);

    // directed corners
    runDiv(31, 1, 0);
    runDiv(31, 31, 0);
    runDiv(0, 7, 0);
    runDiv(5, 9, 0);
    runDiv(29, 0, 0);  // R5 zero divisor
    runDiv(0, 0, 0);   // R5
    idleHold(3);
    runDiv(30, 4, 1);  // R6 start held while busy
    runDiv(17, 3, 2);  // R6 start toggled while busy
    idleHold(2);
    // R9 back-to-back: each runDiv begins in the cycle ready returned
    runDiv(26, 5, 0);
    runDiv(13, 2, 0);
    // R2 operands scrambled after accept inside runDiv
    for (int k = 0; k < 400; k++) begin
      runDiv(int'($urandom_range(31, 0)), int'($urandom_range(31, 0)), int'($urandom_range(2, 0)));
      if (k % 7 == 0) idleHold(1);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule